// File: doc/BRIEF.md
# Word-Serial CORDIC Engine

This block evaluates rotations and angle measurements with shift-and-add arithmetic. A single micro-rotation stage is reused once per clock, so a full result costs a fixed number of cycles, but the arithmetic exists only once. A parameter fixes the function at build time: plain vector rotation, polar-to-rectangular conversion, rectangular-to-polar conversion, sine and cosine of an angle, or the arctangent of a ratio.

A producer places an X, Y and angle word on the inputs and raises `din_valid` while `rdy` is high. The engine then drops `rdy`, runs `NUM_ITER` micro-rotations, raises `rdy` again and a little later presents the result with a one-cycle `dout_valid` pulse. The controller has three states. IDLE waits with `rdy` high and moves to RUN when a strobe is accepted. RUN performs one micro-rotation per cycle and moves to WRAP after the last one. WRAP hands the result to the output pipeline and returns to IDLE. The output pipeline truncates the result in a hold stage, blanks the words that carry no meaning in a select stage, and then drives the output stage. The internal datapath is `IN_W+2` bits wide. Results are truncated, and angles must lie within ±π/2.

Top module: `cordic_serial`

## Requirements
- R1: The parameter `MODE` selects the function: 0 rotation, 1 polar-to-rectangular, 2 rectangular-to-polar, 3 sine/cosine, 4 arctangent. Linear inputs are two's complement scaled by 2^(IN_W-2). Linear outputs are scaled by 2^(OUT_W-3). Angles are fractions of π, scaled by 2^(IN_W-2) at the input and 2^(OUT_W-2) at the output.
- R2: `rdy` is high after either reset while idle. A `din_valid` seen at a rising edge with `rdy` high is accepted, and `rdy` is low in the following cycle.
- R3: `rdy` rises again exactly NUM_ITER+1 cycles after the accepting edge.
- R4: `dout_valid` is a single-cycle pulse that appears exactly NUM_ITER+3 cycles after the accepting edge, once per accepted input.
- R5: A `din_valid` seen while `rdy` is low is ignored. This holds even in the last busy cycle, and it changes neither the result nor the timing.
- R6: In rotation mode, outputs X and Y equal K·(x·cosA − y·sinA) and K·(y·cosA + x·sinA), with K the product of √(1+2^(−2i)) over the iterations (about 1.64676). The bench accepts results within 8 output LSBs.
- R7: In polar-to-rectangular mode the Y input is ignored and treated as 0. The outputs are K·R·cosA and K·R·sinA.
- R8: In rectangular-to-polar mode with x > 0, the angle input is ignored. Output X is K·√(x²+y²) and output A is atan(y/x).
- R9: In sine/cosine mode the engine starts from X = 1/K and Y = 0, whatever the X and Y inputs hold. Outputs X and Y are cosA and sinA with no gain.
- R10: In arctangent mode with x > 0, output A is atan(y/x) and the angle input is ignored.
- R11: Output words with no meaning in a mode read as zero: A in rotation, polar and sine/cosine modes; Y in rectangular-to-polar mode; X and Y in arctangent mode.
- R12: A synchronous reset held high at a rising edge aborts a computation. `rdy` is high after that edge, no `dout_valid` follows, and the next input is processed normally.
- R13: The asynchronous active-low reset forces `rdy` high and `dout_valid` low at once, without waiting for a clock edge.
- R14: An input accepted on the first edge at which `rdy` is high again, back to back with the previous one, yields a correct second result NUM_ITER+3 cycles after its own acceptance. The first result is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| srst | input | 1 | Synchronous reset, active high |
| din_x | input | IN_W | X operand or magnitude |
| din_y | input | IN_W | Y operand |
| din_a | input | IN_W | Angle operand, fraction of π |
| din_valid | input | 1 | Input strobe, taken only while `rdy` is high |
| dout_x | output | OUT_W | X result |
| dout_y | output | OUT_W | Y result |
| dout_a | output | OUT_W | Angle result, fraction of π |
| dout_valid | output | 1 | One-cycle result strobe |
| rdy | output | 1 | Engine can take a new input |

## Verification
The bench aims at the handshake edges. A strobe during the final WRAP cycle would start a second result if the busy window were one cycle too short. A strobe on the very first ready cycle would corrupt the pending output if the hold stage were captured late. An off-by-one iteration counter shows up as `rdy` or `dout_valid` arriving one cycle early or late. The sine/cosine and polar modes are driven with nonzero X and Y inputs, which a missing preload would carry into the results. The angle extremes ±π/2 test convergence at the edge of the range. Both resets are applied mid-computation: a wrong abort would still emit a stale pulse or leave `rdy` low.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

    typedef enum logic [2:0] {
        MD_ROTATE   = 3'd0,
        MD_POL2RECT = 3'd1,
        MD_RECT2POL = 3'd2,
        MD_SINCOS   = 3'd3,
        MD_ATAN     = 3'd4
    } cordic_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_WRAP = 2'd2
    } cordic_state_e;

    localparam real PI_R = 3.14159265358979323846;

    // Magnitude growth after n micro-rotations
    function automatic real cordic_gain(input int n);
        real g;
        g = 1.0;
        for (int i = 0; i < n; i++) begin
            g = g * $sqrt(1.0 + 2.0 ** (-2 * i));
        end
        return g;
    endfunction

endpackage

// File: rtl/cordic_atan_rom.sv
module cordic_atan_rom
    import cordic_pkg::*;
#(
    parameter int DP_W     = 18,
    parameter int NUM_ITER = 16,
    parameter int IW       = 4
) (
    input  logic        [IW-1:0]   idx,
    output logic signed [DP_W-1:0] angle
);

    localparam int DEPTH = 2 ** IW;

    logic signed [DP_W-1:0] tbl [DEPTH];

    // atan(2^-g)/pi scaled so that 1.0 (pi) sits at 2^(DP_W-2)
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        if (g < NUM_ITER) begin : g_used
            localparam real    ANG   = $atan(2.0 ** (-g)) / PI_R * (2.0 ** (DP_W - 2));
            localparam longint ANG_I = longint'(ANG);
            assign tbl[g] = ANG_I[DP_W-1:0];
        end else begin : g_pad
            assign tbl[g] = '0;
        end
    end

    assign angle = tbl[idx];

endmodule

// File: rtl/cordic_micro.sv
module cordic_micro #(
    parameter int DP_W = 18,
    parameter int IW   = 4
) (
    input  logic signed [DP_W-1:0] x_i,
    input  logic signed [DP_W-1:0] y_i,
    input  logic signed [DP_W-1:0] z_i,
    input  logic        [IW-1:0]   sh_i,
    input  logic signed [DP_W-1:0] ang_i,
    input  logic                   vec_i,
    output logic signed [DP_W-1:0] x_o,
    output logic signed [DP_W-1:0] y_o,
    output logic signed [DP_W-1:0] z_o
);

    logic signed [DP_W-1:0] xs;
    logic signed [DP_W-1:0] ys;
    logic                   ccw;

    always_comb begin
        xs = x_i >>> sh_i;
        ys = y_i >>> sh_i;
        // rotation steers the residual angle to zero, vectoring steers y to zero
        ccw = vec_i ? y_i[DP_W-1] : ~z_i[DP_W-1];
        if (ccw) begin
            x_o = x_i - ys;
            y_o = y_i + xs;
            z_o = z_i - ang_i;
        end else begin
            x_o = x_i + ys;
            y_o = y_i - xs;
            z_o = z_i + ang_i;
        end
    end

endmodule

// File: rtl/cordic_ctrl.sv
module cordic_ctrl
    import cordic_pkg::*;
#(
    parameter int NUM_ITER = 16,
    parameter int IW       = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          srst,
    input  logic          in_valid,
    output logic          ready_o,
    output logic          accept_o,
    output logic          step_o,
    output logic          wrap_o,
    output logic [IW-1:0] iter_o
);

    localparam logic [IW-1:0] LAST = IW'(NUM_ITER - 1);

    cordic_state_e st_q, st_nx;
    logic [IW-1:0] iter_q, iter_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            iter_q <= '0;
        end else if (srst) begin
            st_q   <= ST_IDLE;
            iter_q <= '0;
        end else begin
            st_q   <= st_nx;
            iter_q <= iter_nx;
        end
    end

    // transitions and outputs
    always_comb begin
        st_nx    = st_q;
        iter_nx  = iter_q;
        ready_o  = 1'b0;
        accept_o = 1'b0;
        step_o   = 1'b0;
        wrap_o   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                ready_o = 1'b1;
                if (in_valid) begin
                    accept_o = 1'b1;
                    iter_nx  = '0;
                    st_nx    = ST_RUN;
                end
            end
            ST_RUN: begin
                step_o  = 1'b1;
                iter_nx = iter_q + 1'b1;
                if (iter_q == LAST) begin
                    st_nx = ST_WRAP;
                end
            end
            ST_WRAP: begin
                wrap_o = 1'b1;
                st_nx  = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    assign iter_o = iter_q;

    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n || srst)
        accept_o |=> (!ready_o && iter_q == '0)); // R2
    AST_ITER_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n || srst)
        (st_q == ST_RUN && iter_q != LAST) |=> (st_q == ST_RUN && iter_q == $past(iter_q) + 1'b1)); // R3
    AST_WRAP_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n || srst)
        wrap_o |=> ready_o); // R3

endmodule

// File: rtl/cordic_serial.sv
module cordic_serial
    import cordic_pkg::*;
#(
    parameter int IN_W     = 16,
    parameter int OUT_W    = 16,
    parameter int NUM_ITER = 16,
    parameter int MODE     = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    srst,
    input  logic signed [IN_W-1:0]  din_x,
    input  logic signed [IN_W-1:0]  din_y,
    input  logic signed [IN_W-1:0]  din_a,
    input  logic                    din_valid,
    output logic signed [OUT_W-1:0] dout_x,
    output logic signed [OUT_W-1:0] dout_y,
    output logic signed [OUT_W-1:0] dout_a,
    output logic                    dout_valid,
    output logic                    rdy
);

    // automatic datapath: two guard bits above the input width
    localparam int EXT  = 2;
    localparam int DP_W = IN_W + EXT;
    localparam int IW   = (NUM_ITER > 1) ? $clog2(NUM_ITER) : 1;
    // linear: DP holds 2^(IN_W-2) per unit, output wants 2^(OUT_W-3); needs OUT_W <= IN_W+1
    localparam int LSH  = IN_W + 1 - OUT_W;
    // angle: DP holds 2^(DP_W-2) per pi, output wants 2^(OUT_W-2)
    localparam int ASH  = DP_W - OUT_W;

    localparam cordic_mode_e MD = cordic_mode_e'(3'(MODE));
    localparam logic VEC = (MD == MD_RECT2POL) || (MD == MD_ATAN);
    localparam logic ZERO_Y = (MD == MD_POL2RECT) || (MD == MD_SINCOS);

    localparam longint INV_K_I = longint'((2.0 ** (IN_W - 2)) / cordic_gain(NUM_ITER));
    localparam logic signed [DP_W-1:0] INV_K_W = INV_K_I[DP_W-1:0];

    logic          accept, step, wrap;
    logic [IW-1:0] iter;

    cordic_ctrl #(
        .NUM_ITER (NUM_ITER),
        .IW       (IW)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst     (srst),
        .in_valid (din_valid),
        .ready_o  (rdy),
        .accept_o (accept),
        .step_o   (step),
        .wrap_o   (wrap),
        .iter_o   (iter)
    );

    logic signed [DP_W-1:0] ang;

    cordic_atan_rom #(
        .DP_W     (DP_W),
        .NUM_ITER (NUM_ITER),
        .IW       (IW)
    ) u_rom (
        .idx   (iter),
        .angle (ang)
    );

    logic signed [DP_W-1:0] x_q, y_q, z_q;
    logic signed [DP_W-1:0] x_nx, y_nx, z_nx;

    cordic_micro #(
        .DP_W (DP_W),
        .IW   (IW)
    ) u_micro (
        .x_i   (x_q),
        .y_i   (y_q),
        .z_i   (z_q),
        .sh_i  (iter),
        .ang_i (ang),
        .vec_i (VEC),
        .x_o   (x_nx),
        .y_o   (y_nx),
        .z_o   (z_nx)
    );

    // mode-dependent preload
    logic signed [DP_W-1:0] x_ld, y_ld, z_ld;

    always_comb begin
        x_ld = (MD == MD_SINCOS) ? INV_K_W : {{EXT{din_x[IN_W-1]}}, din_x};
        y_ld = ZERO_Y ? '0 : {{EXT{din_y[IN_W-1]}}, din_y};
        z_ld = VEC ? '0 : {din_a, {EXT{1'b0}}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
            z_q <= '0;
        end else if (srst) begin
            x_q <= '0;
            y_q <= '0;
            z_q <= '0;
        end else if (accept) begin
            x_q <= x_ld;
            y_q <= y_ld;
            z_q <= z_ld;
        end else if (step) begin
            x_q <= x_nx;
            y_q <= y_nx;
            z_q <= z_nx;
        end
    end

    // hold stage (truncation), select stage, output stage
    logic signed [OUT_W-1:0] hold_x, hold_y, hold_a;
    logic                    hold_v;
    logic signed [OUT_W-1:0] sel_x, sel_y, sel_a;
    logic signed [OUT_W-1:0] pick_x, pick_y, pick_a;
    logic                    pick_v;

    always_comb begin
        sel_x = hold_x;
        sel_y = hold_y;
        sel_a = hold_a;
        unique case (MD)
            MD_RECT2POL: sel_y = '0;
            MD_ATAN: begin
                sel_x = '0;
                sel_y = '0;
            end
            default: sel_a = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_v <= 1'b0;
            hold_x <= '0;
            hold_y <= '0;
            hold_a <= '0;
            pick_v <= 1'b0;
            pick_x <= '0;
            pick_y <= '0;
            pick_a <= '0;
            dout_valid <= 1'b0;
            dout_x <= '0;
            dout_y <= '0;
            dout_a <= '0;
        end else if (srst) begin
            hold_v <= 1'b0;
            hold_x <= '0;
            hold_y <= '0;
            hold_a <= '0;
            pick_v <= 1'b0;
            pick_x <= '0;
            pick_y <= '0;
            pick_a <= '0;
            dout_valid <= 1'b0;
            dout_x <= '0;
            dout_y <= '0;
            dout_a <= '0;
        end else begin
            hold_v <= wrap;
            if (wrap) begin
                hold_x <= x_q[LSH +: OUT_W];
                hold_y <= y_q[LSH +: OUT_W];
                hold_a <= z_q[ASH +: OUT_W];
            end
            pick_v <= hold_v;
            if (hold_v) begin
                pick_x <= sel_x;
                pick_y <= sel_y;
                pick_a <= sel_a;
            end
            dout_valid <= pick_v;
            if (pick_v) begin
                dout_x <= pick_x;
                dout_y <= pick_y;
                dout_a <= pick_a;
            end
        end
    end

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n || srst)
        dout_valid |=> !dout_valid); // R4
    AST_OUT_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n || srst)
        dout_valid |-> ($past(rdy, 2) && !$past(rdy, 3))); // R4

    if (MD == MD_ATAN) begin : g_chk_atan
        AST_UNUSED_ZERO_AT: assert property (@(posedge clk) disable iff (!rst_n || srst)
            dout_valid |-> (dout_x == '0 && dout_y == '0)); // R11
    end else if (MD == MD_RECT2POL) begin : g_chk_polar
        AST_UNUSED_ZERO_RP: assert property (@(posedge clk) disable iff (!rst_n || srst)
            dout_valid |-> (dout_y == '0)); // R11
    end else begin : g_chk_rot
        AST_UNUSED_ZERO_ROT: assert property (@(posedge clk) disable iff (!rst_n || srst)
            dout_valid |-> (dout_a == '0)); // R11
    end

endmodule

// File: tb/tb_cordic_serial.sv
module tb_cordic_serial;

    localparam int ITER = 16;
    localparam int NV   = 5;
    localparam int NM   = 5;
    localparam real LSC = 8192.0;   // 2^(OUT_W-3)
    localparam real ASC = 16384.0;  // 2^(OUT_W-2)
    localparam real ISC = 16384.0;  // 2^(IN_W-2)
    localparam real TOL = 8.0;
    localparam real PI  = 3.14159265358979323846;

    // x, y, angle (input scale 2^14, angle as fraction of pi)
    localparam int STIM [NV][3] = '{
        '{  8192,  4096,  4096 },
        '{ -4915,  9830, -6554 },
        '{ 11469, -8192,  1638 },
        '{ 14746,     0, -8192 },
        '{  3277, 13107,  8192 }
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic srst = 1'b0;
    logic din_valid = 1'b0;
    logic signed [15:0] din_x = '0, din_y = '0, din_a = '0;

    logic signed [15:0] ox [NM];
    logic signed [15:0] oy [NM];
    logic signed [15:0] oa [NM];
    logic               ov [NM];
    logic               rd [NM];

    always #10 clk = ~clk;

    for (genvar m = 0; m < NM; m++) begin : g_mode
        cordic_serial #(
            .IN_W(16), .OUT_W(16), .NUM_ITER(ITER), .MODE(m)
        ) dut (
            .clk(clk), .rst_n(rst_n), .srst(srst),
            .din_x(din_x), .din_y(din_y), .din_a(din_a), .din_valid(din_valid),
            .dout_x(ox[m]), .dout_y(oy[m]), .dout_a(oa[m]),
            .dout_valid(ov[m]), .rdy(rd[m])
        );
    end

    int n_chk = 0;
    int n_fail = 0;
    int p_cnt;
    int p_edge [2];
    int rdy_edge;
    int seen_rdy, seen_ov;
    real kg;
    logic signed [15:0] cx [2][NM];
    logic signed [15:0] cy [2][NM];
    logic signed [15:0] ca [2][NM];

    task automatic chk_eq(input string tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic chk_near(input string tag, input int act, input real expv);
        real d;
        n_chk++;
        d = act - expv;
        if (d < 0.0) d = -d;
        if (d > TOL) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0.2f", tag, act, expv);
        end
    endtask

    task automatic set_in(input int r);
        din_x = 16'(STIM[r][0]);
        din_y = 16'(STIM[r][1]);
        din_a = 16'(STIM[r][2]);
    endtask

    task automatic start(input int r);
        @(negedge clk);
        set_in(r);
        din_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        din_valid = 1'b0;
        chk_eq("R2 ready low after accept", int'(rd[0]), 0);
    endtask

    // kind: 0 none, 1 extra strobe with row r_inj, 2 sync reset, 3 async reset
    task automatic track(input int kind, input int k_inj, input int r_inj);
        p_cnt = 0;
        p_edge[0] = -1;
        p_edge[1] = -1;
        rdy_edge = -1;
        for (int k = 1; k <= 2 * ITER + 8; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (kind != 0 && k == k_inj + 1) begin
                din_valid = 1'b0;
                srst = 1'b0;
                rst_n = 1'b1;
            end
            if (rd[0] && rdy_edge < 0) rdy_edge = k;
            if (ov[0]) begin
                if (p_cnt < 2) begin
                    p_edge[p_cnt] = k;
                    for (int m = 0; m < NM; m++) begin
                        cx[p_cnt][m] = ox[m];
                        cy[p_cnt][m] = oy[m];
                        ca[p_cnt][m] = oa[m];
                    end
                end
                p_cnt++;
            end
            if (k == k_inj) begin
                case (kind)
                    1: begin set_in(r_inj); din_valid = 1'b1; end
                    2: srst = 1'b1;
                    3: begin
                        rst_n = 1'b0;
                        #1;
                        seen_rdy = int'(rd[0]);
                        seen_ov = int'(ov[0]);
                    end
                    default: ;
                endcase
            end
        end
    endtask

    task automatic check_results(input int pi, input int r);
        real fx, fy, ar;
        fx = STIM[r][0] / ISC;
        fy = STIM[r][1] / ISC;
        ar = STIM[r][2] / ISC * PI;
        // R6 rotation
        chk_near("R6 rotate x", int'(cx[pi][0]), kg * (fx * $cos(ar) - fy * $sin(ar)) * LSC);
        chk_near("R6 rotate y", int'(cy[pi][0]), kg * (fy * $cos(ar) + fx * $sin(ar)) * LSC);
        chk_eq("R11 rotate a zero", int'(ca[pi][0]), 0);
        // R7 polar to rectangular, y input ignored
        chk_near("R7 polar x", int'(cx[pi][1]), kg * fx * $cos(ar) * LSC);
        chk_near("R7 polar y", int'(cy[pi][1]), kg * fx * $sin(ar) * LSC);
        // R9 sine/cosine, x and y inputs ignored
        chk_near("R9 cos", int'(cx[pi][3]), $cos(ar) * LSC);
        chk_near("R9 sin", int'(cy[pi][3]), $sin(ar) * LSC);
        chk_eq("R11 sincos a zero", int'(ca[pi][3]), 0);
        if (fx > 0.0) begin
            // R8 rectangular to polar, angle input ignored
            chk_near("R8 magnitude", int'(cx[pi][2]), kg * $sqrt(fx * fx + fy * fy) * LSC);
            chk_near("R8 phase", int'(ca[pi][2]), $atan2(fy, fx) / PI * ASC);
            chk_eq("R11 rect y zero", int'(cy[pi][2]), 0);
            // R10 arctangent
            chk_near("R10 atan", int'(ca[pi][4]), $atan2(fy, fx) / PI * ASC);
            chk_eq("R11 atan x zero", int'(cx[pi][4]), 0);
            chk_eq("R11 atan y zero", int'(cy[pi][4]), 0);
        end
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        kg = 1.0;
        for (int i = 0; i < ITER; i++) kg = kg * $sqrt(1.0 + 2.0 ** (-2 * i));

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int m = 0; m < NM; m++) begin
            chk_eq("R2 ready after reset", int'(rd[m]), 1);
            chk_eq("R2 no output after reset", int'(ov[m]), 0);
        end

        // vector table walk: R1 mode functions, R3/R4 timing
        for (int r = 0; r < NV; r++) begin
            start(r);
            track(0, 0, 0);
            chk_eq("R3 ready rise edge", rdy_edge, ITER + 1);
            chk_eq("R4 pulse count", p_cnt, 1);
            chk_eq("R4 pulse edge", p_edge[0], ITER + 3);
            check_results(0, r);
        end

        // R5: strobe while busy, mid-run and in the last busy cycle
        start(0);
        track(1, 3, 2);
        chk_eq("R5 mid-run strobe pulse count", p_cnt, 1);
        chk_eq("R5 mid-run ready edge", rdy_edge, ITER + 1);
        check_results(0, 0);
        start(1);
        track(1, ITER, 3);
        chk_eq("R5 wrap strobe pulse count", p_cnt, 1);
        chk_eq("R5 wrap pulse edge", p_edge[0], ITER + 3);
        check_results(0, 1);

        // R14: back-to-back at minimum spacing
        start(2);
        track(1, ITER + 1, 4);
        chk_eq("R14 pulse count", p_cnt, 2);
        chk_eq("R14 first pulse edge", p_edge[0], ITER + 3);
        chk_eq("R14 second pulse edge", p_edge[1], 2 * ITER + 5);
        check_results(0, 2);
        check_results(1, 4);

        // R12: synchronous reset mid-run
        start(0);
        track(2, 5, 0);
        chk_eq("R12 no pulse after abort", p_cnt, 0);
        chk_eq("R12 ready edge after abort", rdy_edge, 6);
        start(3);
        track(0, 0, 0);
        chk_eq("R12 pulse edge after abort", p_edge[0], ITER + 3);
        check_results(0, 3);

        // R13: asynchronous reset mid-run
        start(1);
        track(3, 5, 0);
        chk_eq("R13 ready during async reset", seen_rdy, 1);
        chk_eq("R13 valid during async reset", seen_ov, 0);
        chk_eq("R13 no pulse after abort", p_cnt, 0);
        start(4);
        track(0, 0, 0);
        chk_eq("R13 pulse edge after abort", p_edge[0], ITER + 3);
        check_results(0, 4);

        summary();
        $finish;
    end

endmodule